// File: doc/BRIEF.md
# Flash Bad Block Keeper

This block decides which physical blocks of a NAND-style flash array may hold data and keeps a table of one flag per block. After reset it scans the whole array on its own: for each block it reads the first byte of the spare area of page 0. If that byte still holds the erased value 0xFF, it also reads the same byte of page 1. A block is unusable when either byte differs from 0xFF. While this scan runs a busy flag stays high.

Once the scan is over, the block accepts error reports from the rest of the flash subsystem. Three kinds of report retire a block:
- a failed program;
- a failed erase;
- a read whose ECC could not correct the data.

The table flag is set at the clock edge that accepts the report. The block then requests one write of the marker byte 0x00 into the first spare byte of page 0 of that block, so that a later scan will find it bad as well.

Allocation logic asks about any block through a combinational query port. The block issues no flash commands and computes no ECC itself: reads and marker writes go out through simple request/acknowledge ports.

Top module: `badblk_keeper`

## Requirements
- R1: From reset until the last block has been scanned, `busy` is 1 and `errReady` is 0. An error report offered in that time has no effect. Once `busy` falls it stays 0 until the next reset. The table reads all-good during reset.
- R2: The scan reads blocks in ascending order from 0 to NUM_BLOCKS-1. Each read is for page 0 at column SPARE_COL (2048 by default). A read completes in a cycle where `rdReq` and `rdValid` are both 1.
- R3: When the page 0 marker byte is not 0xFF, the block is flagged bad, page 1 of that block is not read, and the scan moves to the next block.
- R4: When the page 0 marker byte is 0xFF, page 1 of the same block is read at column SPARE_COL. The block is flagged bad if that byte is not 0xFF, and good if both bytes are 0xFF.
- R5: An accepted report with `errKind` = 1 (program failure) sets the block's flag, visible on `qBad` in the cycle after acceptance.
- R6: An accepted report with `errKind` = 2 (erase failure) sets the block's flag in the same way.
- R7: An accepted report with `errKind` = 3 (uncorrectable ECC error) sets the block's flag in the same way.
- R8: An accepted report with `errKind` = 0 (no retiring error) changes no flag and causes no marker write.
- R9: In the cycle after a retiring report is accepted, `wrReq` is 1 with `wrBlock` = the reported block, `wrPage` = 0, `wrCol` = SPARE_COL and `wrData` = 0x00. It stays so until a cycle with `wrAck` = 1. While `wrReq` is 1, `errReady` is 0.
- R10: `qBad` follows `qBlock` combinationally, with no clock edge in between.
- R11: A flag once set stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busy | output | 1 | Power-up scan in progress |
| qBlock | input | BLK_W | Block index to look up |
| qBad | output | 1 | 1 when the queried block must not hold data |
| rdReq | output | 1 | Spare-byte read request |
| rdBlock | output | BLK_W | Block of the read |
| rdPage | output | PAGE_W | Page of the read (0 or 1) |
| rdCol | output | COL_W | Byte column of the read |
| rdValid | input | 1 | Read data valid, completes the read |
| rdData | input | 8 | Byte returned by the read |
| errValid | input | 1 | Error report offered |
| errKind | input | 2 | 0 none, 1 program, 2 erase, 3 uncorrectable ECC |
| errBlock | input | BLK_W | Block the report refers to |
| errReady | output | 1 | Report accepted in a cycle where it and errValid are 1 |
| wrReq | output | 1 | Marker write request |
| wrBlock | output | BLK_W | Block to mark |
| wrPage | output | PAGE_W | Page to write (always 0) |
| wrCol | output | COL_W | Byte column to write |
| wrData | output | 8 | Marker byte (0x00) |
| wrAck | input | 1 | Marker write done |

## Verification
The assertions take for granted that the flash side raises `rdValid` only while `rdReq` is high and `wrAck` only while `wrReq` is high. They also assume a reporter holds `errKind` and `errBlock` steady while `errValid` waits for `errReady`. The bench drives its read responder and marker acknowledge from the request outputs it observes, with random gaps, and it changes report fields only between accepted reports. An early report is offered during the scan only to prove that it is refused.

// File: rtl/badblk_pkg.sv
package badblk_pkg;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_PROG  = 2'd1,
    ERR_ERASE = 2'd2,
    ERR_ECC   = 2'd3
  } errKind_e;

  typedef struct packed {
    logic scanPage;    // 0: page 0 marker, 1: page 1 marker
    logic scanSetBad;  // current scan block found bad
    logic scanNext;    // advance scan index
    logic errTake;     // error report accepted this cycle
    logic errMark;     // accepted report retires a block
  } ctlStrobe_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
  localparam logic [7:0] MARK_BYTE   = 8'h00;

endpackage

// File: rtl/badblk_ctrl.sv
module badblk_ctrl
  import badblk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdValid,
  input  logic       markerErased,
  input  logic       lastBlk,
  input  logic       errValid,
  input  errKind_e   errKind,
  input  logic       wrAck,
  output logic       rdReq,
  output logic       busy,
  output logic       errReady,
  output logic       wrReq,
  output ctlStrobe_t ctl
);

  typedef enum logic [1:0] {ST_SCAN0, ST_SCAN1, ST_RUN, ST_MARK} state_e;

  state_e state, stateNxt;
  logic   rdDone;

  assign rdReq    = (state == ST_SCAN0) || (state == ST_SCAN1);
  assign busy     = rdReq;
  assign errReady = (state == ST_RUN);
  assign wrReq    = (state == ST_MARK);
  assign rdDone   = rdReq && rdValid;

  always_comb begin
    ctl            = '0;
    ctl.scanPage   = (state == ST_SCAN1);
    ctl.scanSetBad = rdDone && !markerErased;
    ctl.scanNext   = ((state == ST_SCAN0) && rdDone && !markerErased) ||
                     ((state == ST_SCAN1) && rdDone);
    ctl.errTake    = errReady && errValid;
    ctl.errMark    = ctl.errTake && (errKind != ERR_NONE);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_SCAN0: if (rdDone) begin
        if (markerErased)  stateNxt = ST_SCAN1;
        else if (lastBlk)  stateNxt = ST_RUN;
      end
      ST_SCAN1: if (rdDone) stateNxt = lastBlk ? ST_RUN : ST_SCAN0;
      ST_RUN:   if (ctl.errMark) stateNxt = ST_MARK;
      ST_MARK:  if (wrAck) stateNxt = ST_RUN;
      default:  stateNxt = ST_SCAN0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SCAN0;
    else       state <= stateNxt;
  end

  // R1: no report is taken while the scan runs
  a_r1_no_take_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !errReady);
  // R1: scan runs once per reset
  a_r1_busy_stays_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !busy);
  // R3: a bad page 0 marker skips page 1
  a_r3_skip_page1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCAN0 && rdValid && !markerErased) |=> state != ST_SCAN1);
  // R9: marker request held until acknowledged
  a_r9_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck) |=> wrReq);
  // R9: no new report while a marker write is pending
  a_r9_one_pending: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> !errReady);

endmodule

// File: rtl/badblk_dp.sv
module badblk_dp
  import badblk_pkg::*;
#(
  parameter  int NUM_BLOCKS = 64,
  parameter  int PAGE_W     = 6,
  parameter  int COL_W      = 12,
  parameter  int SPARE_COL  = 2048,
  localparam int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [7:0]        rdData,
  input  logic [BLK_W-1:0]  errBlock,
  input  logic [BLK_W-1:0]  qBlock,
  output logic              qBad,
  output logic              markerErased,
  output logic              lastBlk,
  output logic [BLK_W-1:0]  rdBlock,
  output logic [PAGE_W-1:0] rdPage,
  output logic [COL_W-1:0]  rdCol,
  output logic [BLK_W-1:0]  wrBlock,
  output logic [PAGE_W-1:0] wrPage,
  output logic [COL_W-1:0]  wrCol,
  output logic [7:0]        wrData
);

  localparam int               TABLE_SZ = 1 << BLK_W;
  localparam logic [BLK_W-1:0] LAST_IDX = BLK_W'(NUM_BLOCKS - 1);

  logic [BLK_W-1:0]    scanIdx;
  logic [BLK_W-1:0]    markBlk;
  logic [TABLE_SZ-1:0] badTable;

  assign markerErased = (rdData == ERASED_BYTE);
  assign lastBlk      = (scanIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN)                         scanIdx <= '0;
    else if (ctl.scanNext && !lastBlk) scanIdx <= scanIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            markBlk <= '0;
    else if (ctl.errMark) markBlk <= errBlock;
  end

  // One flag cell per block; indices past the array read as unusable.
  for (genvar gi = 0; gi < TABLE_SZ; gi++) begin : g_cell
    if (gi < NUM_BLOCKS) begin : g_real
      logic setHit;
      assign setHit = (ctl.scanSetBad && scanIdx  == BLK_W'(gi)) ||
                      (ctl.errMark    && errBlock == BLK_W'(gi));
      always_ff @(posedge clk) begin
        if (!rstN)       badTable[gi] <= 1'b0;
        else if (setHit) badTable[gi] <= 1'b1;
      end
    end else begin : g_pad
      assign badTable[gi] = 1'b1;
    end
  end

  assign qBad    = badTable[qBlock];
  assign rdBlock = scanIdx;
  assign rdPage  = ctl.scanPage ? PAGE_W'(1) : '0;
  assign rdCol   = COL_W'(SPARE_COL);
  assign wrBlock = markBlk;
  assign wrPage  = '0;
  assign wrCol   = COL_W'(SPARE_COL);
  assign wrData  = MARK_BYTE;

  // R11: flags never clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (!rstN)
    &(~$past(badTable) | badTable));
  // R5: a retiring report sets the flag of the latched block
  a_r5_mark_sets: assert property (@(posedge clk) disable iff (!rstN)
    ctl.errMark |=> badTable[markBlk]);
  // R8: a non-retiring report leaves the table untouched
  a_r8_none_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.errTake && !ctl.errMark && !ctl.scanSetBad) |=> badTable == $past(badTable));
  // R2: scan index moves by one only
  a_r2_ascending: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.scanNext && !lastBlk) |=> scanIdx == $past(scanIdx) + 1'b1);

endmodule

// File: rtl/badblk_keeper.sv
module badblk_keeper
  import badblk_pkg::*;
#(
  parameter  int NUM_BLOCKS = 64,
  parameter  int PAGE_W     = 6,
  parameter  int COL_W      = 12,
  parameter  int SPARE_COL  = 2048,
  localparam int BLK_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              busy,
  input  logic [BLK_W-1:0]  qBlock,
  output logic              qBad,
  output logic              rdReq,
  output logic [BLK_W-1:0]  rdBlock,
  output logic [PAGE_W-1:0] rdPage,
  output logic [COL_W-1:0]  rdCol,
  input  logic              rdValid,
  input  logic [7:0]        rdData,
  input  logic              errValid,
  input  logic [1:0]        errKind,
  input  logic [BLK_W-1:0]  errBlock,
  output logic              errReady,
  output logic              wrReq,
  output logic [BLK_W-1:0]  wrBlock,
  output logic [PAGE_W-1:0] wrPage,
  output logic [COL_W-1:0]  wrCol,
  output logic [7:0]        wrData,
  input  logic              wrAck
);

  ctlStrobe_t ctl;
  logic       markerErased;
  logic       lastBlk;

  badblk_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .rdValid      (rdValid),
    .markerErased (markerErased),
    .lastBlk      (lastBlk),
    .errValid     (errValid),
    .errKind      (errKind_e'(errKind)),
    .wrAck        (wrAck),
    .rdReq        (rdReq),
    .busy         (busy),
    .errReady     (errReady),
    .wrReq        (wrReq),
    .ctl          (ctl)
  );

  badblk_dp #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PAGE_W     (PAGE_W),
    .COL_W      (COL_W),
    .SPARE_COL  (SPARE_COL)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .rdData       (rdData),
    .errBlock     (errBlock),
    .qBlock       (qBlock),
    .qBad         (qBad),
    .markerErased (markerErased),
    .lastBlk      (lastBlk),
    .rdBlock      (rdBlock),
    .rdPage       (rdPage),
    .rdCol        (rdCol),
    .wrBlock      (wrBlock),
    .wrPage       (wrPage),
    .wrCol        (wrCol),
    .wrData       (wrData)
  );

endmodule

// File: tb/test_badblk_keeper.sv
`timescale 1ns/1ps
module test_badblk_keeper;

  localparam int  N      = 32;
  localparam int  BW     = $clog2(N);
  localparam int  PW     = 6;
  localparam int  CW     = 12;
  localparam int  SPARE  = 2048;
  localparam real CLK_NS = 8.0;

  logic          clk = 1'b0;
  logic          rstN;
  logic          busy, qBad, rdReq, rdValid, errValid, errReady, wrReq, wrAck;
  logic [BW-1:0] qBlock, rdBlock, errBlock, wrBlock;
  logic [PW-1:0] rdPage, wrPage;
  logic [CW-1:0] rdCol, wrCol;
  logic [7:0]    rdData, wrData;
  logic [1:0]    errKind;

  badblk_keeper #(.NUM_BLOCKS(N), .PAGE_W(PW), .COL_W(CW), .SPARE_COL(SPARE)) i_badblk_keeper (
    .clk(clk), .rstN(rstN), .busy(busy), .qBlock(qBlock), .qBad(qBad),
    .rdReq(rdReq), .rdBlock(rdBlock), .rdPage(rdPage), .rdCol(rdCol),
    .rdValid(rdValid), .rdData(rdData), .errValid(errValid), .errKind(errKind),
    .errBlock(errBlock), .errReady(errReady), .wrReq(wrReq), .wrBlock(wrBlock),
    .wrPage(wrPage), .wrCol(wrCol), .wrData(wrData), .wrAck(wrAck)
  );

  always #(CLK_NS/2) clk = ~clk;

  int       nChecks = 0;
  int       nFail   = 0;
  logic [7:0] p0Mark [N];
  logic [7:0] p1Mark [N];
  bit       expBad [N];
  int       nReads = 0;
  bit       scanOn = 0;
  bit       doneFlag = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
  endtask

  function automatic bit scanVerdict(input logic [7:0] m0, input logic [7:0] m1);
    return (m0 != 8'hFF) || (m1 != 8'hFF);
  endfunction

  // Flash read responder, driven on falling edges
  initial begin
    int expBlk  = 0;
    int expPage = 0;
    int gap     = 0;
    rdValid = 1'b0;
    rdData  = 8'h00;
    forever begin
      @(negedge clk);
      if (!scanOn) begin
        rdValid = 1'b0;
        expBlk = 0; expPage = 0;
      end else if (rdValid) begin
        rdValid = 1'b0;
        gap = $urandom % 3;
      end else if (rdReq) begin
        if (gap > 0) gap--;
        else begin
          chk(rdBlock == BW'(expBlk), expPage ? "R4 block" : "R2 block", rdBlock, expBlk);
          chk(rdPage == PW'(expPage), expPage ? "R4 page" : "R3 page", rdPage, expPage);
          chk(rdCol == CW'(SPARE), "R2 column", rdCol, SPARE);
          rdData  = expPage ? p1Mark[expBlk] : p0Mark[expBlk];
          rdValid = 1'b1;
          nReads++;
          if (expPage == 0 && rdData == 8'hFF) expPage = 1;
          else begin expPage = 0; expBlk++; end
        end
      end
    end
  end

  task automatic report(input logic [1:0] kind, input int blk);
    int  hold;
    bit  prev;
    string tag;
    tag = (kind == 2'd1) ? "R5" : (kind == 2'd2) ? "R6" : (kind == 2'd3) ? "R7" : "R8";
    prev = expBad[blk];
    @(negedge clk);
    errValid = 1'b1; errKind = kind; errBlock = BW'(blk);
    for (int w = 0; w < 20 && !errReady; w++) @(negedge clk);
    @(negedge clk);
    errValid = 1'b0;
    qBlock = BW'(blk);
    #1;
    if (kind != 2'd0) begin
      expBad[blk] = 1'b1;
      chk(qBad == 1'b1, tag, qBad, 1);
      chk(wrReq == 1'b1, "R9 request", wrReq, 1);
      chk(wrBlock == BW'(blk), "R9 block", wrBlock, blk);
      chk(wrPage == '0 && wrCol == CW'(SPARE), "R9 address", {wrPage, wrCol}, SPARE);
      chk(wrData == 8'h00, "R9 data", wrData, 0);
      hold = $urandom % 4;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(wrReq == 1'b1 && errReady == 1'b0, "R9 hold", wrReq, 1);
      end
      wrAck = 1'b1;
      @(negedge clk);
      wrAck = 1'b0;
      chk(wrReq == 1'b0 && errReady == 1'b1, "R9 release", wrReq, 0);
    end else begin
      chk(qBad == prev, "R8 flag", qBad, prev);
      chk(wrReq == 1'b0, "R8 no write", wrReq, 0);
    end
  endtask

  task automatic sweep(input string tag);
    for (int b = 0; b < N; b++) begin
      qBlock = BW'(b);
      #1;
      chk(qBad == expBad[b], tag, qBad, expBad[b]);
    end
  endtask

  initial begin
    int expReads;
    void'($urandom(32'd1234));
    rstN = 1'b0; qBlock = '0; errValid = 1'b0; errKind = '0; errBlock = '0; wrAck = 1'b0;
    for (int b = 0; b < N; b++) begin
      p0Mark[b] = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
      p1Mark[b] = ($urandom % 4 == 0) ? 8'($urandom) : 8'hFF;
    end
    p0Mark[0] = 8'h00; p1Mark[0] = 8'hFF;
    p0Mark[1] = 8'hFF; p1Mark[1] = 8'h7F;
    p0Mark[2] = 8'hFF; p1Mark[2] = 8'hFF;
    p0Mark[3] = 8'hFE; p1Mark[3] = 8'h00;
    p0Mark[4] = 8'hFF; p1Mark[4] = 8'hFF;
    p0Mark[5] = 8'hFF; p1Mark[5] = 8'hFF;
    p0Mark[6] = 8'hFF; p1Mark[6] = 8'hFF;
    p0Mark[7] = 8'hFF; p1Mark[7] = 8'hFF;
    p0Mark[N-1] = 8'hFF; p1Mark[N-1] = 8'hFE;
    expReads = 0;
    for (int b = 0; b < N; b++) begin
      expBad[b] = scanVerdict(p0Mark[b], p1Mark[b]);
      expReads += (p0Mark[b] == 8'hFF) ? 2 : 1;
    end
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy in reset", busy, 1);
    qBlock = BW'(0); #1;
    chk(qBad == 1'b0, "R1 table clear in reset", qBad, 0);
    rstN = 1'b1;
    scanOn = 1;
    // A report offered early must be refused (R1)
    errValid = 1'b1; errKind = 2'd1; errBlock = BW'(2);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      chk(busy == 1'b1 && errReady == 1'b0, "R1 refuse during scan", errReady, 0);
    end
    errValid = 1'b0;
    for (int c = 0; c < 5000 && busy; c++) @(negedge clk);
    chk(busy == 1'b0, "R1 scan ends", busy, 0);
    chk(nReads == expReads, "R2 read count", nReads, expReads);
    sweep("R3 R4 scan verdict");
    qBlock = BW'(1); #1;
    chk(qBad == 1'b1, "R10 combinational query", qBad, 1);
    qBlock = BW'(2); #1;
    chk(qBad == 1'b0, "R10 combinational query", qBad, 0);
    scanOn = 0;
    report(2'd1, 4);
    report(2'd2, 5);
    report(2'd3, 6);
    report(2'd0, 7);
    report(2'd0, 0);
    report(2'd3, 4);
    for (int k = 0; k < 40; k++) report(2'($urandom), int'($urandom % N));
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy stays low", busy, 0);
    sweep("R11 flags kept");
    summary();
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

endmodule